// File: doc/BRIEF.md
# Boundary Scan Cell Chain

This block is a string of boundary-scan cells sitting between a chip's pins and its core logic. Every cell has a scan flip-flop that either captures the cell's functional input or moves serial data one place along the chain. It also has an update stage that is loaded from the scan flip-flop on the falling test-clock edge. An output multiplexer selects either the functional signal or the held test value. Capture, shift and update strobes come from an external test-port controller. The scan input enters cell 0, and the scan output is the scan flip-flop of the last cell.

A test-mode select and an internal-test select decide which cells drive test values. Each cell also has a direction bit: it faces either the pins (input side, pin to core) or the core (output side, core to pin). In external test, output-side cells drive the pins from their update stages, while input-side cells stay transparent and capture what arrives at the pins. In internal test the roles swap. With the test mode off, the chain is invisible to normal operation, but it can still capture and shift.

Top module: `bscan_chain`

## Requirements
- R1: With mode_test at 0, every par_out bit equals the par_in bit of the same cell, with no clock involved.
- R2: On each rising tck with shift_dr at 1, cell 0 takes scan_in and each cell i takes the value of cell i-1. scan_out shows the last cell's scan flip-flop, so a bit entered at scan_in appears at scan_out after exactly N_CELLS rising edges.
- R3: An update stage changes only on a falling tck edge while update_dr is 1, and it then takes its cell's scan flip-flop. Shifting or capturing without update_dr leaves par_out unchanged.
- R4: On a rising tck with shift_dr at 0 and capture_dr at 1, each scan flip-flop loads its cell's par_in in that one edge.
- R5: With mode_test at 1 and mode_intest at 0, cells with cell_is_out at 1 drive par_out from their update stage. Cells with cell_is_out at 0 pass par_in through and still capture it.
- R6: With mode_test at 1 and mode_intest at 1, cells with cell_is_out at 0 drive par_out from their update stage. Cells with cell_is_out at 1 pass par_in through.
- R7: With mode_test at 0, a capture followed by a full shift returns the par_in values on scan_out, and par_out keeps following par_in throughout.
- R8: While trst_n is low, and until its release has passed two rising tck edges, par_out follows par_in whatever the mode inputs are. Reset also clears all update stages to 0.
- R9: When shift_dr and capture_dr are both 1, the chain shifts and does not capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| scan_in | input | 1 | Serial data into cell 0 |
| shift_dr | input | 1 | 1: shift the chain; 0: capture when capture_dr is 1 |
| capture_dr | input | 1 | Scan flip-flop enable for parallel capture |
| update_dr | input | 1 | Update-stage load, taken on falling tck |
| mode_test | input | 1 | 1: test mode, 0: normal mode |
| mode_intest | input | 1 | 1: internal test, 0: external test |
| cell_is_out | input | N_CELLS | Per-cell direction, 1 = output side |
| par_in | input | N_CELLS | Functional input of each cell |
| par_out | output | N_CELLS | Output of each cell |
| scan_out | output | 1 | Scan flip-flop of cell N_CELLS-1 |

## Verification
A shift or capture result is due at the first rising tck after the strobe, and scan_out shows it at once. A new update value reaches par_out at the falling edge inside the cycle where update_dr is held. Mode changes reach par_out combinationally. The bench drives each input 1 ns after a rising edge and samples before the next one. It checks par_out only after a full cycle with update_dr high, and it reads scan_out before every shift edge, which gives the last cell first.

// File: rtl/bscan_pkg.sv
package bscan_pkg;
  typedef struct packed {
    logic shift;
    logic capture;
    logic update;
  } bscan_ctrl_t;

  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/bscan_rst_sync.sv
module bscan_rst_sync
  import bscan_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_n = sync_q[SYNC_STAGES-1];

  // R8: synchronized reset is low whenever the raw reset is low
  p_rst_follow_r8: assert property (@(posedge clk) !arst_n |-> !rst_n);
endmodule

// File: rtl/bscan_cell.sv
module bscan_cell
  import bscan_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  bscan_ctrl_t ctrl,
  input  logic        ser_in,
  input  logic        func_in,
  input  logic        test_sel,
  output logic        ser_out,
  output logic        cell_out
);
  logic cap_q, cap_d, cap_en;
  logic upd_q;

  always_comb begin
    cap_en = ctrl.shift | ctrl.capture;
    cap_d  = ctrl.shift ? ser_in : func_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cap_q <= 1'b0;
    else if (cap_en) cap_q <= cap_d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)           upd_q <= 1'b0;
    else if (ctrl.update) upd_q <= cap_q;
  end

  always_comb begin
    cell_out = test_sel ? upd_q : func_in;
  end

  assign ser_out = cap_q;

  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.shift |=> cap_q == $past(ser_in));
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.capture && !ctrl.shift) |=> cap_q == $past(func_in));
  p_priority_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.capture && ctrl.shift) |=> cap_q == $past(ser_in));
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.update |-> $stable(upd_q));
  p_update_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.update && $past(ctrl.update)) |-> upd_q == cap_q);
endmodule

// File: rtl/bscan_chain.sv
module bscan_chain
  import bscan_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               scan_in,
  input  logic               shift_dr,
  input  logic               capture_dr,
  input  logic               update_dr,
  input  logic               mode_test,
  input  logic               mode_intest,
  input  logic [N_CELLS-1:0] cell_is_out,
  input  logic [N_CELLS-1:0] par_in,
  output logic [N_CELLS-1:0] par_out,
  output logic               scan_out
);
  localparam int unsigned LAST = N_CELLS - 1;

  logic              rst_n_sync;
  bscan_ctrl_t       ctrl;
  logic [N_CELLS:0]  ser_link;
  logic [LAST:0]     test_sel;

  bscan_rst_sync u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n_sync)
  );

  always_comb begin
    ctrl.shift   = shift_dr;
    ctrl.capture = capture_dr;
    ctrl.update  = update_dr;
  end

  assign ser_link[0] = scan_in;

  for (genvar i = 0; i < N_CELLS; i++) begin : g_cell
    always_comb begin
      test_sel[i] = rst_n_sync & mode_test & (cell_is_out[i] ^ mode_intest);
    end

    bscan_cell u_cell (
      .clk      (tck),
      .rst_n    (rst_n_sync),
      .ctrl     (ctrl),
      .ser_in   (ser_link[i]),
      .func_in  (par_in[i]),
      .test_sel (test_sel[i]),
      .ser_out  (ser_link[i+1]),
      .cell_out (par_out[i])
    );

    // R5: input-side cells stay transparent in external test
    p_extest_pass_r5: assert property (@(posedge tck) disable iff (!rst_n_sync)
      (mode_test && !mode_intest && !cell_is_out[i]) |-> par_out[i] == par_in[i]);
    // R6: output-side cells stay transparent in internal test
    p_intest_pass_r6: assert property (@(posedge tck) disable iff (!rst_n_sync)
      (mode_test && mode_intest && cell_is_out[i]) |-> par_out[i] == par_in[i]);
  end

  assign scan_out = ser_link[N_CELLS];

  p_normal_r1: assert property (@(posedge tck) disable iff (!rst_n_sync)
    !mode_test |-> par_out == par_in);
  p_reset_pass_r8: assert property (@(posedge tck)
    !rst_n_sync |-> par_out == par_in);
  p_scan_chain_r2: assert property (@(posedge tck) disable iff (!rst_n_sync)
    shift_dr |=> scan_out == $past(g_cell[LAST].u_cell.ser_in));
endmodule

// File: tb/bscan_chain_tb.sv
module bscan_chain_tb_top;
  localparam int N = 8;
  localparam logic [N-1:0] DIRS = 8'hF0;

  logic tck = 1'b0;
  logic trst_n, scan_in, shift_dr, capture_dr, update_dr, mode_test, mode_intest;
  logic [N-1:0] cell_is_out, par_in, par_out;
  logic scan_out;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 tck = ~tck;

  bscan_chain #(.N_CELLS(N)) dut_i (
    .tck(tck), .trst_n(trst_n), .scan_in(scan_in), .shift_dr(shift_dr),
    .capture_dr(capture_dr), .update_dr(update_dr), .mode_test(mode_test),
    .mode_intest(mode_intest), .cell_is_out(cell_is_out), .par_in(par_in),
    .par_out(par_out), .scan_out(scan_out)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge tck);
    #1;
  endtask

  task automatic shift_in(input logic [N-1:0] v);
    for (int k = N - 1; k >= 0; k--) begin
      shift_dr = 1'b1; scan_in = v[k];
      step();
    end
    shift_dr = 1'b0; scan_in = 1'b0;
  endtask

  task automatic do_update();
    update_dr = 1'b1;
    step();
    update_dr = 1'b0;
  endtask

  task automatic do_capture();
    capture_dr = 1'b1;
    step();
    capture_dr = 1'b0;
  endtask

  task automatic shift_out(output logic [N-1:0] r, input logic [N-1:0] hold_exp, input string req);
    for (int k = N - 1; k >= 0; k--) begin
      r[k] = scan_out;
      if (par_out !== hold_exp) begin
        checks++; errors++;
        $display("FAIL %s par_out moved during shift actual %h expected %h", req, par_out, hold_exp);
      end
      shift_dr = 1'b1; scan_in = 1'b0;
      step();
    end
    shift_dr = 1'b0;
  endtask

  task automatic t_reset();
    trst_n = 1'b0; mode_test = 1'b1; mode_intest = 1'b0;
    par_in = 8'h5A;
    #1;
    check("R8 pass in reset", par_out, 8'h5A);
    step(); step();
    trst_n = 1'b1;
    step(); step(); step();
    check("R8 latches clear", par_out, (8'h00 & DIRS) | (8'h5A & ~DIRS));
  endtask

  task automatic t_normal();
    mode_test = 1'b0;
    par_in = 8'hC3; #1;
    check("R1 normal a", par_out, 8'hC3);
    par_in = 8'h1E; #1;
    check("R1 normal b", par_out, 8'h1E);
  endtask

  task automatic t_extest();
    logic [N-1:0] r;
    mode_test = 1'b1; mode_intest = 1'b0; par_in = 8'h3C;
    shift_in(8'hA5);
    check("R3 no update yet", par_out, (8'h00 & DIRS) | (8'h3C & ~DIRS));
    do_update();
    check("R5 extest drive", par_out, 8'hAC);
    do_capture();
    check("R4 capture scan_out", {7'b0, scan_out}, {7'b0, 1'b0});
    shift_out(r, 8'hAC, "R3");
    check("R4 captured pins", r, 8'h3C);
    check("R3 outputs held after shift", par_out, 8'hAC);
  endtask

  task automatic t_intest();
    mode_intest = 1'b1; par_in = 8'h3C; #1;
    check("R6 intest drive", par_out, 8'h35);
    par_in = 8'hC3; #1;
    check("R6 intest pass", par_out, (8'hA5 & ~DIRS) | (8'hC3 & DIRS));
  endtask

  task automatic t_observe();
    logic [N-1:0] r;
    mode_test = 1'b0; par_in = 8'h96;
    do_capture();
    shift_out(r, 8'h96, "R7");
    check("R7 observe", r, 8'h96);
    check("R7 normal kept", par_out, 8'h96);
  endtask

  task automatic t_latency();
    shift_in(8'h00);
    shift_dr = 1'b1; scan_in = 1'b1;
    step();
    scan_in = 1'b0;
    for (int k = 2; k <= N; k++) begin
      check("R2 early", {7'b0, scan_out}, 8'h00);
      step();
    end
    check("R2 arrival", {7'b0, scan_out}, 8'h01);
    shift_dr = 1'b0;
  endtask

  task automatic t_priority();
    logic [N-1:0] r;
    shift_in(8'h00);
    par_in = 8'hFF;
    shift_dr = 1'b1; capture_dr = 1'b1; scan_in = 1'b1;
    step();
    capture_dr = 1'b0; shift_dr = 1'b0; scan_in = 1'b0;
    shift_out(r, 8'hFF, "R9");
    check("R9 shift wins", r, 8'h01);
  endtask

  initial begin
    scan_in = 0; shift_dr = 0; capture_dr = 0; update_dr = 0;
    cell_is_out = DIRS;
    t_reset();
    t_normal();
    t_extest();
    t_intest();
    t_observe();
    t_latency();
    t_priority();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule